// File: doc/BRIEF.md
# Tiered Physical Memory Protection Permission Checker

This block decides whether a single memory access is allowed by a small array of physical memory protection entries. Each request carries an address, an access kind (read, write or execute), the effective privilege (machine or supervisor/user) and a flag that lets executable supervisor/user memory also be read. The block finds the lowest-numbered entry whose address region covers the request. It then grants or denies the access using four inputs: that entry's two-bit privilege field, its execute/write/read bits, a global two-bit security tier and a global default-closed bit.

The decision logic is combinational. The fault verdict and the index of the deciding entry are registered one cycle after a valid request. When nothing matched, the index reads all ones. Entries describe their regions either as top-of-range bounds or as naturally aligned power-of-two blocks. The configuration is presented on flat input buses and is owned by the surrounding logic.

Top module: `pmp_tier_check`

## Requirements
- R1: When several entries match an address, only the lowest-numbered matching entry decides the access. All higher-numbered entries are ignored.
- R2: Address mode is a two-bit field per entry: 0 = off, 1 = top-of-range, 2 = power-of-two, 3 = reserved. Modes 0 and 3 never match. A top-of-range entry i matches when the previous entry's address word is at most the address and the address is below entry i's own address word. Entry 0 uses 0 as its lower bound.
- R3: In power-of-two mode, let t be the number of trailing ones in the entry's address word. Address bits 0 to t are ignored, and every higher bit must equal the stored bit. An all-ones word matches every address.
- R4: At tier 0, the privilege field is split on its upper bit. Fields 0 and 1 allow machine mode every access and apply the XWR bits to supervisor/user. Fields 2 and 3 apply the XWR bits to every privilege. The XWR bits are bit 2 = X, bit 1 = W, bit 0 = R.
- R5: At tiers 1 to 3, field 0 allows machine mode to read and write but never to execute, and applies XWR to supervisor/user. Field 1 denies every machine access and applies XWR to supervisor/user.
- R6: At tiers 1 to 3, fields 2 and 3 apply XWR to machine mode and deny every supervisor/user access.
- R7: When no entry matches and default-closed is 1, every access faults.
- R8: When no entry matches and default-closed is 0, every supervisor/user access faults. Machine mode gets every access at tiers 0 and 1. At tiers 2 and 3 it gets read and write, and execute faults.
- R9: For a supervisor/user read with the make-executable-readable input at 1, an entry whose XWR bits are applied to supervisor/user grants the read when its X bit is set, even if R is clear.
- R10: A request with valid high at a clock edge produces, at that edge, rsp_valid = 1 with the fault verdict and the deciding index. The index is clog2(entries)+1 bits wide and reads all ones when nothing matched. rsp_valid is 0 after any edge without a request. Reset gives rsp_valid = 0, rsp_fault = 0 and the index all ones.
- R11: Access kind is encoded 0 = read, 1 = write, 2 = execute. Kind 3 is reserved and always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Access address, in entry address units |
| req_kind | input | 2 | Access kind (R11 encoding) |
| req_mach | input | 1 | 1 = machine effective privilege, 0 = supervisor/user |
| req_mxr | input | 1 | Make executable memory readable for supervisor/user reads |
| sec_level | input | 2 | Global security tier 0..3 |
| default_closed | input | 1 | Deny everything that matches no entry |
| ent_mode | input | 2*N_ENT | Per-entry address mode, entry i at bits [2i+1:2i] |
| ent_priv | input | 2*N_ENT | Per-entry privilege field, entry i at bits [2i+1:2i] |
| ent_xwr | input | 3*N_ENT | Per-entry X/W/R bits, entry i at bits [3i+2:3i] |
| ent_addr | input | N_ENT*ADDR_W | Per-entry address word, entry i at slice i |
| rsp_valid | output | 1 | Verdict valid |
| rsp_fault | output | 1 | 1 = access denied |
| rsp_index | output | clog2(N_ENT)+1 | Deciding entry, all ones when nothing matched |

## Verification
Two of the block's functions often fall in the same cycle. Region matching on several entries happens at once, and the priority pick has to resolve those overlapping hits. The permission tier and the no-match default rule also meet in the same verdict, which is chosen by whether any entry hit at all. Random configurations use narrow addresses so that overlapping top-of-range and power-of-two regions occur often. Directed cases place a deny entry below an allow entry over the same region. Every verdict and index is judged against a bench model that scans the entries from the highest index down, and against the tier table written out per field.

// File: rtl/pmp_tier_pkg.sv
package pmp_tier_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NAPOT = 2'd2,
        AM_RSVD  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } xwr_t;

    typedef struct packed {
        acc_e kind;
        logic mach;
        logic mxr;
    } acc_req_t;

    // Rule bits applied to the request; the readable-executable widening only for S/U.
    function automatic logic xwr_grants(xwr_t p, acc_req_t q);
        logic rd_ok;
        rd_ok = p.r | (q.mxr & ~q.mach & p.x);
        case (q.kind)
            ACC_READ:  return rd_ok;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

    // Verdict for a matched entry.
    function automatic logic rule_allows(logic [1:0] tier, logic [1:0] field, xwr_t p, acc_req_t q);
        logic locked;
        locked = field[1];
        if (q.kind == ACC_BAD)
            return 1'b0;
        if (tier == 2'd0) begin
            if (locked || !q.mach)
                return xwr_grants(p, q);
            return 1'b1;
        end
        if (locked)
            return q.mach ? xwr_grants(p, q) : 1'b0;
        if (!q.mach)
            return xwr_grants(p, q);
        return (field == 2'd0) && (q.kind != ACC_EXEC);
    endfunction

    // Verdict when no entry matched.
    function automatic logic miss_allows(logic [1:0] tier, logic closed, acc_req_t q);
        if (closed || !q.mach || q.kind == ACC_BAD)
            return 1'b0;
        if (tier[1])
            return q.kind != ACC_EXEC;
        return 1'b1;
    endfunction

endpackage

// File: rtl/pmp_tier_match.sv
module pmp_tier_match
    import pmp_tier_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] this_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] care_mask;
    logic              tor_hit;
    logic              pow_hit;

    // Ones from bit 0 through the lowest zero of the stored word.
    assign care_mask = this_addr ^ (this_addr + 1'b1);
    assign pow_hit   = ((req_addr ^ this_addr) & ~care_mask) == '0;
    assign tor_hit   = (req_addr >= prev_addr) && (req_addr < this_addr);

    always_comb begin
        case (amode_e'(mode))
            AM_TOR:   hit = tor_hit;
            AM_NAPOT: hit = pow_hit;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmp_tier_prio.sv
module pmp_tier_prio #(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        win_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i])
                win_idx = IDX_W'(i);
        end
    end
    assign any_hit = |hits;
endmodule

// File: rtl/pmp_tier_decide.sv
module pmp_tier_decide
    import pmp_tier_pkg::*;
(
    input  logic       any_hit,
    input  logic [1:0] sel_priv,
    input  logic [2:0] sel_xwr,
    input  logic [1:0] tier,
    input  logic       closed,
    input  logic [1:0] kind,
    input  logic       mach,
    input  logic       mxr,
    output logic       fault
);
    acc_req_t q;
    logic     ok;

    always_comb begin
        q.kind = acc_e'(kind);
        q.mach = mach;
        q.mxr  = mxr;
        if (any_hit)
            ok = rule_allows(tier, sel_priv, xwr_t'(sel_xwr), q);
        else
            ok = miss_allows(tier, closed, q);
        fault = ~ok;
    end
endmodule

// File: rtl/pmp_tier_check.sv
module pmp_tier_check
    import pmp_tier_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_kind,
    input  logic                    req_mach,
    input  logic                    req_mxr,
    input  logic [1:0]              sec_level,
    input  logic                    default_closed,
    input  logic [2*N_ENT-1:0]      ent_mode,
    input  logic [2*N_ENT-1:0]      ent_priv,
    input  logic [3*N_ENT-1:0]      ent_xwr,
    input  logic [N_ENT*ADDR_W-1:0] ent_addr,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [IDX_W:0]          rsp_index
);
    localparam logic [IDX_W:0] NO_HIT = '1;

    logic [N_ENT-1:0] hits;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    logic [1:0]       sel_priv;
    logic [2:0]       sel_xwr;
    logic             fault_c;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [ADDR_W-1:0] lower;
        if (g == 0) begin : g_first
            assign lower = '0;
        end else begin : g_rest
            assign lower = ent_addr[(g-1)*ADDR_W +: ADDR_W];
        end
        pmp_tier_match #(.ADDR_W(ADDR_W)) u_match (
            .mode      (ent_mode[2*g +: 2]),
            .this_addr (ent_addr[g*ADDR_W +: ADDR_W]),
            .prev_addr (lower),
            .req_addr  (req_addr),
            .hit       (hits[g])
        );
    end

    pmp_tier_prio #(.N_ENT(N_ENT)) u_prio (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    assign sel_priv = ent_priv[2*win_idx +: 2];
    assign sel_xwr  = ent_xwr[3*win_idx +: 3];

    pmp_tier_decide u_decide (
        .any_hit  (any_hit),
        .sel_priv (sel_priv),
        .sel_xwr  (sel_xwr),
        .tier     (sec_level),
        .closed   (default_closed),
        .kind     (req_kind),
        .mach     (req_mach),
        .mxr      (req_mxr),
        .fault    (fault_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_index <= NO_HIT;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= fault_c;
                rsp_index <= any_hit ? {1'b0, win_idx} : NO_HIT;
            end
        end
    end
endmodule

// File: rtl/pmp_tier_check_sva.sv
module pmp_tier_check_sva #(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             req_mach,
    input logic [1:0]       sec_level,
    input logic             default_closed,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [IDX_W:0]   rsp_index
);
    localparam logic [IDX_W:0] NO_HIT = '1;

    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    index_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_index < (IDX_W+1)'(N_ENT)) || (rsp_index == NO_HIT));

    // R7
    closed_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_index == NO_HIT && $past(default_closed)) |-> rsp_fault);

    // R8
    su_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_index == NO_HIT && !$past(req_mach)) |-> rsp_fault);

    // R8
    mach_open_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_index == NO_HIT && $past(req_mach) && !$past(default_closed)
         && !$past(sec_level[1]) && $past(req_kind) != 2'd3) |-> !rsp_fault);
endmodule

bind pmp_tier_check pmp_tier_check_sva #(.N_ENT(N_ENT)) u_sva (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .req_mach       (req_mach),
    .sec_level      (sec_level),
    .default_closed (default_closed),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_index      (rsp_index)
);

// File: tb/pmp_tier_check_bench.sv
module pmp_tier_check_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 12;
    localparam int IW = 3;
    localparam logic [IW:0] NONE = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_kind = '0;
    logic req_mach = 1'b0;
    logic req_mxr = 1'b0;
    logic [1:0] sec_level = '0;
    logic default_closed = 1'b0;
    logic [2*N-1:0] ent_mode;
    logic [2*N-1:0] ent_priv;
    logic [3*N-1:0] ent_xwr;
    logic [N*AW-1:0] ent_addr;
    logic rsp_valid, rsp_fault;
    logic [IW:0] rsp_index;

    logic [1:0]    m_mode [N];
    logic [1:0]    m_priv [N];
    logic [2:0]    m_xwr  [N];
    logic [AW-1:0] m_addr [N];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_mode[2*i +: 2]  = m_mode[i];
            ent_priv[2*i +: 2]  = m_priv[i];
            ent_xwr[3*i +: 3]   = m_xwr[i];
            ent_addr[i*AW +: AW] = m_addr[i];
        end
    end

    pmp_tier_check #(.N_ENT(N), .ADDR_W(AW)) u_pmp_tier_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_mach(req_mach), .req_mxr(req_mxr),
        .sec_level(sec_level), .default_closed(default_closed),
        .ent_mode(ent_mode), .ent_priv(ent_priv), .ent_xwr(ent_xwr), .ent_addr(ent_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_index(rsp_index)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ent_hit(int i, logic [AW-1:0] a);
        logic [AW-1:0] lo;
        int t;
        if (m_mode[i] == 2'd1) begin
            lo = (i == 0) ? '0 : m_addr[i-1];
            return (a >= lo) && (a < m_addr[i]);
        end
        if (m_mode[i] == 2'd2) begin
            t = 0;
            while (t < AW && m_addr[i][t]) t++;
            for (int b = t + 1; b < AW; b++)
                if (a[b] != m_addr[i][b]) return 0;
            return 1;
        end
        return 0;
    endfunction

    function automatic int find_idx(logic [AW-1:0] a);
        int w = -1;
        for (int i = N - 1; i >= 0; i--)
            if (ent_hit(i, a)) w = i;
        return w;
    endfunction

    function automatic bit exp_ok(int w, logic [1:0] k, bit m, bit x, logic [1:0] lv, bit cl);
        bit rule;
        logic [2:0] p;
        if (k == 2'd3) return 0;
        if (w < 0) begin
            if (cl || !m) return 0;
            return (lv < 2) ? 1 : (k != 2'd2);
        end
        p = m_xwr[w];
        case (k)
            2'd0: rule = p[0] || (x && !m && p[2]);
            2'd1: rule = p[1];
            default: rule = p[2];
        endcase
        if (lv == 0) return (m_priv[w] >= 2) ? rule : (m ? 1 : rule);
        case (m_priv[w])
            2'd0: return m ? (k != 2'd2) : rule;
            2'd1: return m ? 0 : rule;
            default: return m ? rule : 0;
        endcase
    endfunction

    function automatic string tag_of(int w, logic [1:0] k, bit m, bit x, logic [1:0] lv, bit cl);
        if (k == 2'd3) return "R11";
        if (w < 0) return cl ? "R7" : "R8";
        if (x && !m && k == 2'd0) return "R9";
        if (lv == 0) return "R4";
        return (m_priv[w] < 2) ? "R5" : "R6";
    endfunction

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            m_mode[i] = 0; m_priv[i] = 0; m_xwr[i] = 0; m_addr[i] = 0;
        end
    endtask

    task automatic drive(logic [AW-1:0] a, logic [1:0] k, bit m, bit x);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = k; req_mach = m; req_mxr = x;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic model_req(logic [AW-1:0] a, logic [1:0] k, bit m, bit x);
        int w;
        bit ok;
        string tg;
        w  = find_idx(a);
        ok = exp_ok(w, k, m, x, sec_level, default_closed);
        tg = tag_of(w, k, m, x, sec_level, default_closed);
        drive(a, k, m, x);
        check({tg, " valid"}, 8'(rsp_valid), 8'd1);
        check({tg, " fault"}, 8'(rsp_fault), 8'(!ok));
        check({tg, " index"}, 8'(rsp_index), (w < 0) ? 8'(NONE) : 8'(w));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        clear_all();
        repeat (3) @(negedge clk);
        check("R10 reset valid", 8'(rsp_valid), 8'd0);
        check("R10 reset fault", 8'(rsp_fault), 8'd0);
        check("R10 reset index", 8'(rsp_index), 8'(NONE));
        rst = 0;

        // R1: deny entry 0 overlays allow entry 1
        sec_level = 0; default_closed = 0;
        m_mode[0] = 2; m_addr[0] = 12'h10F; m_xwr[0] = 3'b000; m_priv[0] = 0;
        m_mode[1] = 2; m_addr[1] = 12'h10F; m_xwr[1] = 3'b111; m_priv[1] = 0;
        drive(12'h105, 2'd0, 0, 0);
        check("R1 fault", 8'(rsp_fault), 8'd1);
        check("R1 index", 8'(rsp_index), 8'd0);

        // R3: region 0x100..0x11F
        drive(12'h11F, 2'd0, 0, 0);
        check("R3 top inside", 8'(rsp_index), 8'd0);
        drive(12'h120, 2'd0, 0, 0);
        check("R3 past top", 8'(rsp_index), 8'(NONE));
        drive(12'h0FF, 2'd0, 0, 0);
        check("R3 below base", 8'(rsp_index), 8'(NONE));

        // R2: off entry never matches; top-of-range bounds
        clear_all();
        m_mode[0] = 0; m_addr[0] = 12'h200;
        m_mode[1] = 1; m_addr[1] = 12'h300; m_xwr[1] = 3'b001;
        drive(12'h200, 2'd0, 0, 0);
        check("R2 tor low bound", 8'(rsp_index), 8'd1);
        check("R2 tor allow", 8'(rsp_fault), 8'd0);
        drive(12'h300, 2'd0, 0, 0);
        check("R2 tor upper excl", 8'(rsp_index), 8'(NONE));
        drive(12'h1FF, 2'd0, 0, 0);
        check("R2 off entry", 8'(rsp_index), 8'(NONE));
        m_mode[0] = 1;
        drive(12'h000, 2'd0, 0, 0);
        check("R2 entry0 base zero", 8'(rsp_index), 8'd0);

        // R11: reserved kind faults even for machine on open miss
        clear_all();
        drive(12'h050, 2'd3, 1, 0);
        check("R11 reserved kind", 8'(rsp_fault), 8'd1);

        // R9: X-only S/U entry read with and without widening
        m_mode[0] = 2; m_addr[0] = 12'h7FF; m_xwr[0] = 3'b100; m_priv[0] = 0;
        sec_level = 1;
        drive(12'h010, 2'd0, 0, 1);
        check("R9 mxr read", 8'(rsp_fault), 8'd0);
        drive(12'h010, 2'd0, 0, 0);
        check("R9 plain read", 8'(rsp_fault), 8'd1);

        // R8: tier 2 machine execute on open miss
        clear_all();
        sec_level = 2;
        drive(12'h010, 2'd2, 1, 0);
        check("R8 tier2 exec", 8'(rsp_fault), 8'd1);
        drive(12'h010, 2'd1, 1, 0);
        check("R8 tier2 write", 8'(rsp_fault), 8'd0);

        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10 idle", 8'(rsp_valid), 8'd0);

        // Random configurations with overlapping regions
        for (int c = 0; c < 150; c++) begin
            for (int i = 0; i < N; i++) begin
                m_mode[i] = 2'($urandom_range(0, 3));
                m_priv[i] = 2'($urandom_range(0, 3));
                m_xwr[i]  = 3'($urandom_range(0, 7));
                m_addr[i] = AW'($urandom_range(0, 4095));
                if ($urandom_range(0, 2) == 0) m_addr[i] = m_addr[i] | 12'h0FF;
            end
            sec_level = 2'($urandom_range(0, 3));
            default_closed = ($urandom_range(0, 3) == 0);
            for (int r = 0; r < 12; r++)
                model_req(AW'($urandom_range(0, 4095)), 2'($urandom_range(0, 3)),
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule